// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one integer by another over several clock cycles, using a single trial subtractor. A partial-remainder register and a quotient register form one long shift register. In each step that pair moves left by one bit, and the divisor is subtracted from the partial remainder. If the trial result is negative, the old value is kept, which restores it, and a 0 enters the quotient from the right. Otherwise the difference is kept and a 1 enters.

A client pulses `start` with both operands and a signed/unsigned select while the block is idle. `busy` is high for the whole operation. `done` pulses once, in the cycle where `quotient`, `remainder` and the combined `result` word become valid. Signed operands are divided as magnitudes, and the signs are applied to the results afterwards.

The block raises no flag and takes no trap for a zero divisor or for signed overflow. Software checks for those cases. A parameter sets how many restoring steps are chained in one clock cycle.

Top module: `seq_restoring_div`

## Requirements
- R1: In unsigned mode (`is_signed`=0) with a non-zero divisor, quotient × divisor + remainder equals the dividend, and remainder < divisor.
- R2: In signed mode (`is_signed`=1), both operands are two's complement. The quotient is truncated toward zero and is negated when the operand signs differ. A non-zero remainder carries the sign of the dividend.
- R3: A zero divisor raises no flag. In unsigned mode the quotient is all ones and the remainder equals the dividend. In signed mode the remainder equals the dividend, and the quotient is all ones for a non-negative dividend or 1 for a negative one.
- R4: An accepted `start` makes `busy` high from the next cycle for WIDTH/UNROLL cycles (32 by default). `done` is then high for exactly one cycle, with `busy` low in that cycle.
- R5: A `start` pulse while `busy` is high is ignored: the running operation completes with its own operands, and no extra `done` occurs.
- R6: `result` is the double-width word with the quotient in bits WIDTH-1:0 and the remainder in bits 2·WIDTH-1:WIDTH.
- R7: `quotient`, `remainder` and `result` change only in a cycle in which `done` is high, and hold their value until the next completion.
- R8: After reset, `busy` and `done` are low and `quotient`, `remainder` and `result` are zero.
- R9: The signed most-negative value divided by −1 gives quotient 0x80000000 and remainder 0, with no flag.
- R10: In unsigned mode, operands with the top bit set divide correctly (for example 0xFFFFFFFF / 0x80000001 gives quotient 1 and remainder 0x7FFFFFFE).
- R11: 8 divided by 3 gives quotient 2 and remainder 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; taken only while idle |
| dividend | input | WIDTH | Numerator |
| divisor | input | WIDTH | Denominator |
| is_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results become valid |
| quotient | output | WIDTH | Quotient of the last completed division |
| remainder | output | WIDTH | Remainder of the last completed division |
| result | output | 2*WIDTH | {remainder, quotient} |

## Verification
Several properties are checked on every cycle:
- the exact cycle count from accepted start to completion, and that `done` is a single cycle with `busy` low (R4);
- that outputs hold between completions (R7);
- the unsigned division identity and the unsigned zero-divisor result, against operands the checker captures at acceptance (R1, R3);
- the remainder sign in signed mode (R2).

Some behaviour shows only in the bench's scenarios, where a scoreboard compares each completion with a value computed independently:
- the signed quotient values, including the most-negative by −1 case (R2, R9);
- the signed zero-divisor results (R3);
- the reset values (R8);
- the layout of the combined word (R6);
- that a start pulse issued mid-operation produces neither a second completion nor a changed result (R5).

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
   typedef enum logic {
      RD_IDLE = 1'b0,
      RD_RUN  = 1'b1
   } rdiv_state_e;
endpackage

// File: rtl/rdiv_magnitude.sv
// Converts an operand to its magnitude and reports whether it was negative.
module rdiv_magnitude #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] value,
   input  logic             is_signed,
   output logic [WIDTH-1:0] mag,
   output logic             negative
);
   always_comb begin
      negative = is_signed & value[WIDTH-1];
      mag      = negative ? (~value + WIDTH'(1)) : value;
   end
endmodule

// File: rtl/rdiv_step.sv
// One restoring iteration: shift {rem, quo} left, trial-subtract, keep or restore.
module rdiv_step #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] rem_in,
   input  logic [WIDTH-1:0] quo_in,
   input  logic [WIDTH-1:0] dvs,
   output logic [WIDTH-1:0] rem_out,
   output logic [WIDTH-1:0] quo_out
);
   // The shifted remainder is below 2*dvs, so WIDTH+1 bits hold the trial exactly.
   logic [WIDTH:0] shifted;
   logic [WIDTH:0] trial;

   always_comb begin
      shifted = {rem_in, quo_in[WIDTH-1]};
      // Subtract by adding the two's complement of the zero-extended divisor.
      trial   = shifted + {1'b1, ~dvs} + (WIDTH+1)'(1);
      if (trial[WIDTH]) begin
         rem_out = shifted[WIDTH-1:0];
         quo_out = {quo_in[WIDTH-2:0], 1'b0};
      end else begin
         rem_out = trial[WIDTH-1:0];
         quo_out = {quo_in[WIDTH-2:0], 1'b1};
      end
   end
endmodule

// File: rtl/rdiv_sign_fix.sv
// Applies the result signs after a magnitude division.
module rdiv_sign_fix #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] quo_mag,
   input  logic [WIDTH-1:0] rem_mag,
   input  logic             neg_quo,
   input  logic             neg_rem,
   output logic [WIDTH-1:0] quo,
   output logic [WIDTH-1:0] rem
);
   always_comb begin
      quo = neg_quo ? (~quo_mag + WIDTH'(1)) : quo_mag;
      rem = neg_rem ? (~rem_mag + WIDTH'(1)) : rem_mag;
   end
endmodule

// File: rtl/seq_restoring_div.sv
module seq_restoring_div
   import rdiv_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter int UNROLL = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [WIDTH-1:0]     dividend,
   input  logic [WIDTH-1:0]     divisor,
   input  logic                 is_signed,
   output logic                 busy,
   output logic                 done,
   output logic [WIDTH-1:0]     quotient,
   output logic [WIDTH-1:0]     remainder,
   output logic [2*WIDTH-1:0]   result
);
   localparam int ITER  = WIDTH / UNROLL;
   localparam int CNT_W = $clog2(ITER + 1);

   initial begin
      assert (WIDTH >= 2) else $fatal(1, "seq_restoring_div: WIDTH must be at least 2");
      assert (UNROLL >= 1 && (WIDTH % UNROLL) == 0)
         else $fatal(1, "seq_restoring_div: UNROLL must divide WIDTH");
   end

   rdiv_state_e       state_q;
   logic [WIDTH-1:0]  rem_q, quo_q, dvs_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              neg_quo_q, neg_rem_q;
   logic              done_q;
   logic [WIDTH-1:0]  quotient_q, remainder_q;

   // operand conditioning
   logic [WIDTH-1:0]  dvd_mag, dvs_mag;
   logic              dvd_neg, dvs_neg;

   rdiv_magnitude #(.WIDTH(WIDTH)) u_dvd_mag (
      .value(dividend), .is_signed(is_signed), .mag(dvd_mag), .negative(dvd_neg)
   );
   rdiv_magnitude #(.WIDTH(WIDTH)) u_dvs_mag (
      .value(divisor), .is_signed(is_signed), .mag(dvs_mag), .negative(dvs_neg)
   );

   // chain of restoring steps evaluated in one cycle
   logic [WIDTH-1:0]  chain_rem [UNROLL+1];
   logic [WIDTH-1:0]  chain_quo [UNROLL+1];

   assign chain_rem[0] = rem_q;
   assign chain_quo[0] = quo_q;

   for (genvar s = 0; s < UNROLL; s++) begin : g_step
      rdiv_step #(.WIDTH(WIDTH)) u_step (
         .rem_in (chain_rem[s]),
         .quo_in (chain_quo[s]),
         .dvs    (dvs_q),
         .rem_out(chain_rem[s+1]),
         .quo_out(chain_quo[s+1])
      );
   end

   // sign correction of the final magnitudes
   logic [WIDTH-1:0]  fix_quo, fix_rem;

   rdiv_sign_fix #(.WIDTH(WIDTH)) u_fix (
      .quo_mag(chain_quo[UNROLL]),
      .rem_mag(chain_rem[UNROLL]),
      .neg_quo(neg_quo_q),
      .neg_rem(neg_rem_q),
      .quo    (fix_quo),
      .rem    (fix_rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= RD_IDLE;
         rem_q       <= '0;
         quo_q       <= '0;
         dvs_q       <= '0;
         cnt_q       <= '0;
         neg_quo_q   <= 1'b0;
         neg_rem_q   <= 1'b0;
         done_q      <= 1'b0;
         quotient_q  <= '0;
         remainder_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            RD_IDLE: begin
               if (start) begin
                  rem_q     <= '0;
                  quo_q     <= dvd_mag;
                  dvs_q     <= dvs_mag;
                  cnt_q     <= CNT_W'(ITER);
                  neg_quo_q <= dvd_neg ^ dvs_neg;
                  neg_rem_q <= dvd_neg;
                  state_q   <= RD_RUN;
               end
            end
            RD_RUN: begin
               rem_q <= chain_rem[UNROLL];
               quo_q <= chain_quo[UNROLL];
               cnt_q <= cnt_q - CNT_W'(1);
               if (cnt_q == CNT_W'(1)) begin
                  state_q     <= RD_IDLE;
                  done_q      <= 1'b1;
                  quotient_q  <= fix_quo;
                  remainder_q <= fix_rem;
               end
            end
            default: state_q <= RD_IDLE;
         endcase
      end
   end

   assign busy      = (state_q == RD_RUN);
   assign done      = done_q;
   assign quotient  = quotient_q;
   assign remainder = remainder_q;
   assign result    = {remainder_q, quotient_q};
endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
   parameter int WIDTH  = 32,
   parameter int UNROLL = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [WIDTH-1:0]   dividend,
   input logic [WIDTH-1:0]   divisor,
   input logic               is_signed,
   input logic               busy,
   input logic               done,
   input logic [WIDTH-1:0]   quotient,
   input logic [WIDTH-1:0]   remainder,
   input logic [2*WIDTH-1:0] result
);
   localparam int ITER = WIDTH / UNROLL;

   logic [WIDTH-1:0]   cap_dvd, cap_dvs;
   logic               cap_sgn;
   int                 lat;
   logic [2*WIDTH-1:0] recon;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_dvd <= '0;
         cap_dvs <= '0;
         cap_sgn <= 1'b0;
         lat     <= 0;
      end else if (start && !busy) begin
         cap_dvd <= dividend;
         cap_dvs <= divisor;
         cap_sgn <= is_signed;
         lat     <= 0;
      end else if (busy) begin
         lat <= lat + 1;
      end
   end

   always_comb
      recon = {{WIDTH{1'b0}}, quotient} * {{WIDTH{1'b0}}, cap_dvs}
            + {{WIDTH{1'b0}}, remainder};

   p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> lat == ITER);
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(quotient) && $stable(remainder) && $stable(result)));
   p_identity_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cap_sgn && cap_dvs != '0) |->
         (recon == {{WIDTH{1'b0}}, cap_dvd} && remainder < cap_dvs));
   p_zero_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cap_sgn && cap_dvs == '0) |->
         (quotient == {WIDTH{1'b1}} && remainder == cap_dvd));
   p_rem_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cap_sgn && remainder != '0) |-> remainder[WIDTH-1] == cap_dvd[WIDTH-1]);
endmodule

bind seq_restoring_div rdiv_checker #(.WIDTH(WIDTH), .UNROLL(UNROLL)) u_rdiv_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
   .is_signed(is_signed), .busy(busy), .done(done), .quotient(quotient),
   .remainder(remainder), .result(result)
);

// File: tb/seq_restoring_div_test.sv
module seq_restoring_div_test;
   localparam int W = 32;

   typedef struct {
      logic [W-1:0] q;
      logic [W-1:0] r;
      string        req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  dividend = '0;
   logic [W-1:0]  divisor = '0;
   logic          is_signed = 1'b0;
   logic          busy, done;
   logic [W-1:0]  quotient, remainder;
   logic [2*W-1:0] result;

   int checks = 0;
   int errors = 0;
   int issued = 0;
   int completed = 0;
   int busy_len = 0;
   logic prev_done = 1'b0;
   exp_t sb[$];

   always #2 clk = ~clk;

   seq_restoring_div #(.WIDTH(W), .UNROLL(1)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
      .is_signed(is_signed), .busy(busy), .done(done), .quotient(quotient),
      .remainder(remainder), .result(result)
   );

   function automatic void chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endfunction

   // Expected results from the requirements (R1, R2, R3)
   function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic s, output logic [W-1:0] q,
                                 output logic [W-1:0] r);
      longint sa, sb_v;
      if (b == '0) begin
         r = a;
         q = (s && a[W-1]) ? W'(1) : {W{1'b1}};
      end else if (!s) begin
         q = a / b;
         r = a % b;
      end else begin
         sa   = longint'($signed(a));
         sb_v = longint'($signed(b));
         q = W'(sa / sb_v);
         r = W'(sa % sb_v);
      end
   endfunction

   task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic s, input string req);
      exp_t e;
      @(negedge clk);
      while (busy) @(negedge clk);
      model(a, b, s, e.q, e.r);
      e.req = req;
      sb.push_back(e);
      issued++;
      dividend = a; divisor = b; is_signed = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic drain();
      @(negedge clk);
      while (busy || sb.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // Monitor: compares every completion with the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_done && done) chk("R4", "done longer than one cycle", 64'(done), 64'(0));
         if (done) begin
            completed++;
            chk("R4", "busy cycles before done", 64'(busy_len), 64'(W));
            chk("R4", "busy low with done", 64'(busy), 64'(0));
            busy_len = 0;
            if (sb.size() == 0) begin
               checks++; errors++;
               $display("FAIL R5 unexpected done actual=%h expected=none", quotient);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(e.req, "quotient", 64'(quotient), 64'(e.q));
               chk(e.req, "remainder", 64'(remainder), 64'(e.r));
               chk("R6", "result word", result, {e.r, e.q});
            end
         end else if (busy) begin
            busy_len++;
         end
         prev_done = done;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R4 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] hq, hr;
      repeat (3) @(negedge clk);
      // R8 reset state
      chk("R8", "busy", 64'(busy), 64'(0));
      chk("R8", "done", 64'(done), 64'(0));
      chk("R8", "quotient", 64'(quotient), 64'(0));
      chk("R8", "remainder", 64'(remainder), 64'(0));
      chk("R8", "result", result, 64'(0));
      rst_n = 1'b1;

      issue(32'd8, 32'd3, 1'b0, "R11");
      issue(32'd100, 32'd7, 1'b0, "R1");
      issue(32'd0, 32'd5, 1'b0, "R1");
      issue(32'd5, 32'd9, 1'b0, "R1");
      issue(32'd77, 32'd77, 1'b0, "R1");
      issue(32'hFFFF_FFFF, 32'd1, 1'b0, "R10");
      issue(32'hFFFF_FFFF, 32'h8000_0001, 1'b0, "R10");
      issue(32'h8000_0000, 32'h7FFF_FFFF, 1'b0, "R10");
      issue(-32'sd7, 32'sd2, 1'b1, "R2");
      issue(32'sd7, -32'sd2, 1'b1, "R2");
      issue(-32'sd7, -32'sd2, 1'b1, "R2");
      issue(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R9");
      issue(32'h8000_0000, 32'd1, 1'b1, "R2");
      issue(32'd1234, 32'd0, 1'b0, "R3");
      issue(-32'sd5, 32'd0, 1'b1, "R3");
      issue(32'd5, 32'd0, 1'b1, "R3");
      drain();

      // R5: start pulse in the middle of an operation
      issue(32'd1000, 32'd9, 1'b0, "R5");
      repeat (3) @(negedge clk);
      dividend = 32'd99; divisor = 32'd3; is_signed = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      drain();
      chk("R5", "completions vs accepted starts", 64'(completed), 64'(issued));

      // R7: outputs hold while idle
      hq = quotient; hr = remainder;
      repeat (10) @(negedge clk);
      chk("R7", "quotient held", 64'(quotient), 64'(hq));
      chk("R7", "remainder held", 64'(remainder), 64'(hr));

      for (int i = 0; i < 40; i++) begin
         logic [W-1:0] a, b;
         a = $urandom;
         b = $urandom >> (i % 28);
         issue(a, b, 1'b0, "R1");
      end
      for (int i = 0; i < 40; i++) begin
         logic [W-1:0] a, b;
         a = $urandom;
         b = W'($signed($urandom) >>> (i % 28));
         issue(a, b, 1'b1, "R2");
      end
      drain();
      chk("R5", "final completions vs starts", 64'(completed), 64'(issued));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule